// File: doc/BRIEF.md
# Peripheral Event Routing Channels

This block connects event-producing peripherals to event-consuming logic through six routed channels. Each channel takes one wire from a flat producer bus that is organised as 64 source groups of 8 signals. A source number and a signal number, both held in the channel's control word, pick that wire. Source number zero disconnects the channel.

The picked wire can pass through unchanged, or it can be turned into one-clock pulses on its rising edges, its falling edges or both. An asynchronous-mode bit bypasses the edge logic so that the picked wire reaches the output combinationally. Software can add its own activity to any channel in two ways: a held level, or a one-clock strobe. Both are combined into the output by XOR.

Two trace outputs, start and stop, can each be tied to any one channel and enabled on its own. All settings sit behind a simple word-addressed write/read port with a combinational read.

Top module: `evr_top`

## Requirements
- R1: After reset every control word, the software level bits and the trace settings read back as zero, and every channel output and both trace outputs are low.
- R2: A channel control word sits at byte offset 0x10 + 4·channel. Its signal number is in bits 2:0, source number in bits 21:16, edge mode in bits 25:24 and asynchronous bit in bit 28. All other bits read back as zero.
- R3: When the source number is zero, the picked signal is low whatever the producer bus carries.
- R4: The picked signal is producer bus bit (source·8 + signal).
- R5: Edge mode 0 passes the picked signal to the output combinationally.
- R6: Edge mode 1 gives a one-clock high on the output for each low-to-high change of the picked signal.
- R7: Edge mode 2 gives a one-clock high on the output for each high-to-low change of the picked signal.
- R8: Edge mode 3 gives a one-clock high on the output for every change of the picked signal.
- R9: With the asynchronous bit set, the output follows the picked signal combinationally and the edge mode has no effect.
- R10: Writing 1 to bit n of the strobe word at offset 0x0 inverts channel n's output for exactly the one clock after the write. Writing 0 has no effect, and reading this word returns zero.
- R11: The software level word at offset 0x4 holds one bit per channel in bits 5:0. It reads back, and each set bit inverts its channel output.
- R12: The trace word at offset 0x40 has the start enable in bit 0 with the start channel in bits 3:1, and the stop enable in bit 8 with the stop channel in bits 11:9. Each trace output equals the chosen channel output when its enable is set. It is low when the enable is clear or the chosen channel is 6 or 7.
- R13: Reads of any other offset return zero, and writes to them change nothing.
- R14: The edge history register of each channel is cleared by reset and samples the picked signal on every clock in all modes. Selecting a source that is already high under rising mode therefore yields one pulse on the first clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 10 | Byte address, word aligned, for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| src_bus | input | 512 | Producer signals, group g signal s at bit g·8+s |
| chan_out | output | 6 | Channel outputs |
| trace_start | output | 1 | Trace start event |
| trace_stop | output | 1 | Trace stop event |

## Verification
Register writes take effect at the clock edge that samples `wr_en`. The bench therefore judges a write's results in the low phase after that edge, and a strobe write is checked high in that phase and low one clock later. Edge modes and pass-through are combinational from the producer bus against a history register that updates at each edge. Every bus change is driven at a falling edge and its output is sampled shortly after, so each sample sees exactly one history update since the previous one. Reads are combinational, so the address is driven and `rdata` is sampled within the same low phase.

// File: rtl/evr_pkg.sv
package evr_pkg;
    localparam int NUM_CH     = 6;
    localparam int GROUP_W    = 8;
    localparam int NUM_GROUPS = 64;
    localparam int SIG_W      = $clog2(GROUP_W);
    localparam int SRC_W      = $clog2(NUM_GROUPS);
    localparam int BUS_W      = NUM_GROUPS * GROUP_W;
    localparam int CHSEL_W    = 3;

    // word indices (byte offset / 4)
    localparam int WIDX_STROBE  = 0;
    localparam int WIDX_LEVEL   = 1;
    localparam int WIDX_CH_BASE = 4;
    localparam int WIDX_TRACE   = 16;

    // control word field positions
    localparam int F_SIG_LSB    = 0;
    localparam int F_SRC_LSB    = 16;
    localparam int F_MODE_LSB   = 24;
    localparam int F_BYP_BIT    = 28;
    localparam int F_TSTART_EN  = 0;
    localparam int F_TSTART_LSB = 1;
    localparam int F_TSTOP_EN   = 8;
    localparam int F_TSTOP_LSB  = 9;

    typedef enum logic [1:0] {
        EDGE_PASS = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic              bypass;
        edge_mode_e        mode;
        logic [SRC_W-1:0]  src;
        logic [SIG_W-1:0]  sig;
    } ch_cfg_t;

    typedef struct packed {
        logic               start_en;
        logic [CHSEL_W-1:0] start_ch;
        logic               stop_en;
        logic [CHSEL_W-1:0] stop_ch;
    } trace_cfg_t;

    function automatic ch_cfg_t cfg_from_word(input logic [31:0] w);
        ch_cfg_t c;
        c.sig    = w[F_SIG_LSB +: SIG_W];
        c.src    = w[F_SRC_LSB +: SRC_W];
        c.mode   = edge_mode_e'(w[F_MODE_LSB +: 2]);
        c.bypass = w[F_BYP_BIT];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input ch_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[F_SIG_LSB +: SIG_W]  = c.sig;
        w[F_SRC_LSB +: SRC_W]  = c.src;
        w[F_MODE_LSB +: 2]     = c.mode;
        w[F_BYP_BIT]           = c.bypass;
        return w;
    endfunction

    function automatic trace_cfg_t trace_from_word(input logic [31:0] w);
        trace_cfg_t t;
        t.start_en = w[F_TSTART_EN];
        t.start_ch = w[F_TSTART_LSB +: CHSEL_W];
        t.stop_en  = w[F_TSTOP_EN];
        t.stop_ch  = w[F_TSTOP_LSB +: CHSEL_W];
        return t;
    endfunction

    function automatic logic [31:0] trace_to_word(input trace_cfg_t t);
        logic [31:0] w;
        w = '0;
        w[F_TSTART_EN]                = t.start_en;
        w[F_TSTART_LSB +: CHSEL_W]    = t.start_ch;
        w[F_TSTOP_EN]                 = t.stop_en;
        w[F_TSTOP_LSB +: CHSEL_W]     = t.stop_ch;
        return w;
    endfunction
endpackage

// File: rtl/evr_regs.sv
module evr_regs
    import evr_pkg::*;
#(
    parameter int N_CH   = NUM_CH,
    parameter int ADDR_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output ch_cfg_t [N_CH-1:0]     cfg_o,
    output logic [N_CH-1:0]        level_o,
    output logic [N_CH-1:0]        strobe_o,
    output trace_cfg_t             trace_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_STROBE = WORD_W'(WIDX_STROBE);
    localparam logic [WORD_W-1:0] W_LEVEL  = WORD_W'(WIDX_LEVEL);
    localparam logic [WORD_W-1:0] W_TRACE  = WORD_W'(WIDX_TRACE);

    logic [WORD_W-1:0] word;
    logic [N_CH-1:0]   hit_ch;
    logic              mapped;
    ch_cfg_t [N_CH-1:0] cfg_q;
    logic [N_CH-1:0]   level_q;
    logic [N_CH-1:0]   strobe_q;
    trace_cfg_t        trace_q;
    logic              unused_bits;

    assign word        = addr[ADDR_W-1:2];
    assign unused_bits = ^{addr[1:0], wdata[31:N_CH]};

    for (genvar i = 0; i < N_CH; i++) begin : g_hit
        assign hit_ch[i] = (word == WORD_W'(WIDX_CH_BASE + i));
    end

    assign mapped = (word == W_STROBE) || (word == W_LEVEL) ||
                    (word == W_TRACE)  || (|hit_ch);

    // register state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            level_q  <= '0;
            strobe_q <= '0;
            trace_q  <= '0;
        end else begin
            strobe_q <= '0;
            if (wr_en) begin
                if (word == W_STROBE) strobe_q <= wdata[N_CH-1:0];
                if (word == W_LEVEL)  level_q  <= wdata[N_CH-1:0];
                if (word == W_TRACE)  trace_q  <= trace_from_word(wdata);
                for (int i = 0; i < N_CH; i++) begin
                    if (hit_ch[i]) cfg_q[i] <= cfg_from_word(wdata);
                end
            end
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (word == W_LEVEL) rdata[N_CH-1:0] = level_q;
        if (word == W_TRACE) rdata = trace_to_word(trace_q);
        for (int i = 0; i < N_CH; i++) begin
            if (hit_ch[i]) rdata = cfg_to_word(cfg_q[i]);
        end
    end

    assign cfg_o    = cfg_q;
    assign level_o  = level_q;
    assign strobe_o = strobe_q;
    assign trace_o  = trace_q;

    // R10: strobe lasts only the clock after its write
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && word == W_STROBE) |=> (strobe_q == '0));

    // R10: the strobe word reads as zero
    p_strobe_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (word == W_STROBE) |-> (rdata == '0));

    // R13: unmapped reads return zero
    p_unmapped_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rdata == '0));

    // R13: unmapped writes leave level and trace state alone
    p_unmapped_keep_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=> ($stable(level_q) && $stable(trace_q)));
endmodule

// File: rtl/evr_channel.sv
module evr_channel
    import evr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ch_cfg_t          cfg,
    input  logic [BUS_W-1:0] src_bus,
    input  logic             level,
    input  logic             strobe,
    output logic             ch_out
);
    logic picked;
    logic hist_q;
    logic edged;
    logic proc;

    // source/signal mux; source zero means disconnected
    always_comb begin
        if (cfg.src == '0) picked = 1'b0;
        else               picked = src_bus[{cfg.src, cfg.sig}];
    end

    // history register samples the picked wire every clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= picked;
    end

    always_comb begin
        unique case (cfg.mode)
            EDGE_PASS: edged = picked;
            EDGE_RISE: edged = picked & ~hist_q;
            EDGE_FALL: edged = ~picked & hist_q;
            EDGE_BOTH: edged = picked ^ hist_q;
            default:   edged = 1'b0;
        endcase
    end

    assign proc   = cfg.bypass ? picked : edged;
    assign ch_out = proc ^ level ^ strobe;

    // R3: disconnected channel picks nothing
    p_none_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src == '0) |-> !picked);

    // R6: a rising-mode pulse never lasts two clocks
    p_rise_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == EDGE_RISE && !cfg.bypass && proc)
        |=> (cfg.mode != EDGE_RISE || cfg.bypass || !proc));

    // R7: a falling-mode pulse never lasts two clocks
    p_fall_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == EDGE_FALL && !cfg.bypass && proc)
        |=> (cfg.mode != EDGE_FALL || cfg.bypass || !proc));
endmodule

// File: rtl/evr_trace.sv
module evr_trace
    import evr_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  trace_cfg_t      tcfg,
    input  logic [N_CH-1:0] ch_vec,
    output logic            trace_start,
    output logic            trace_stop
);
    logic start_sel;
    logic stop_sel;

    always_comb begin
        start_sel = 1'b0;
        stop_sel  = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (tcfg.start_ch == CHSEL_W'(i)) start_sel = ch_vec[i];
            if (tcfg.stop_ch  == CHSEL_W'(i)) stop_sel  = ch_vec[i];
        end
    end

    assign trace_start = tcfg.start_en & start_sel;
    assign trace_stop  = tcfg.stop_en  & stop_sel;

    // R12: disabled trace outputs stay low
    p_start_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tcfg.start_en |-> !trace_start);
    p_stop_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tcfg.stop_en |-> !trace_stop);
endmodule

// File: rtl/evr_top.sv
module evr_top
    import evr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [BUS_W-1:0]  src_bus,
    output logic [NUM_CH-1:0] chan_out,
    output logic              trace_start,
    output logic              trace_stop
);
    ch_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]    level;
    logic [NUM_CH-1:0]    strobe;
    trace_cfg_t           tcfg;

    evr_regs #(.N_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .cfg_o    (cfg),
        .level_o  (level),
        .strobe_o (strobe),
        .trace_o  (tcfg)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        evr_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg[i]),
            .src_bus (src_bus),
            .level   (level[i]),
            .strobe  (strobe[i]),
            .ch_out  (chan_out[i])
        );
    end

    evr_trace #(.N_CH(NUM_CH)) u_trace (
        .clk         (clk),
        .rst_n       (rst_n),
        .tcfg        (tcfg),
        .ch_vec      (chan_out),
        .trace_start (trace_start),
        .trace_stop  (trace_stop)
    );
endmodule

// File: tb/tb_evr_top.sv
module tb_evr_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;
    // each entry: {edge mode[1:0], input bit, expected ch0 output}
    localparam logic [3:0] VEC [NVEC] = '{
        4'b01_0_0, 4'b01_1_1, 4'b01_1_0, 4'b01_0_0, 4'b01_1_1,
        4'b10_1_0, 4'b10_0_1, 4'b10_0_0, 4'b10_1_0, 4'b10_0_1,
        4'b11_1_1, 4'b11_1_0, 4'b11_0_1, 4'b11_0_0,
        4'b00_1_1, 4'b00_0_0, 4'b00_1_1
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [9:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [511:0] src_bus = '0;
    logic [5:0]   chan_out;
    logic         trace_start;
    logic         trace_stop;
    int           checks = 0;
    int           errors = 0;
    logic         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evr_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_bus(src_bus), .chan_out(chan_out),
        .trace_start(trace_start), .trace_stop(trace_stop)
    );

    function automatic logic [31:0] mk_ctrl(input logic byp, input logic [1:0] mode,
                                            input logic [5:0] src, input logic [2:0] sig);
        return (32'(byp) << 28) | (32'(mode) << 24) | (32'(src) << 16) | 32'(sig);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [1:0]  cur_mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1 outputs", {24'd0, chan_out, trace_start, trace_stop}, 32'd0);
        rd(10'h004, d); check("R1 level", d, 32'd0);
        rd(10'h010, d); check("R1 ctrl0", d, 32'd0);
        rd(10'h024, d); check("R1 ctrl5", d, 32'd0);
        rd(10'h040, d); check("R1 trace", d, 32'd0);

        // R5 R6 R7 R8: vector walk on channel 0, source 5 signal 3 (bus bit 43)
        cur_mode = VEC[0][3:2];
        wr(10'h010, mk_ctrl(1'b0, cur_mode, 6'd5, 3'd3));
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][3:2] != cur_mode) begin
                cur_mode = VEC[i][3:2];
                wr(10'h010, mk_ctrl(1'b0, cur_mode, 6'd5, 3'd3));
            end
            @(negedge clk);
            src_bus[43] = VEC[i][1];
            #1 check($sformatf("R5-8 mode%0d step%0d", cur_mode, i), 32'(chan_out[0]), 32'(VEC[i][0]));
        end

        // R2: field layout readback
        wr(10'h014, 32'hFFFF_FFFF);
        rd(10'h014, d); check("R2 ctrl1 fields", d, 32'h133F_0007);
        wr(10'h014, 32'd0);

        // R3: source zero ignores the bus
        wr(10'h018, mk_ctrl(1'b0, 2'd0, 6'd0, 3'd5));
        @(negedge clk); src_bus = '1;
        #1 check("R3 none low", 32'(chan_out[2]), 32'd0);
        @(negedge clk); src_bus = '0;

        // R4: index is source*8+signal
        wr(10'h018, mk_ctrl(1'b0, 2'd0, 6'd42, 3'd6));
        @(negedge clk); src_bus[342] = 1'b1;
        #1 check("R4 hit bit 342", 32'(chan_out[2]), 32'd1);
        @(negedge clk); src_bus = '0; src_bus[341] = 1'b1;
        #1 check("R4 neighbour 341", 32'(chan_out[2]), 32'd0);
        @(negedge clk); src_bus = '0; src_bus[350] = 1'b1;
        #1 check("R4 next group 350", 32'(chan_out[2]), 32'd0);
        @(negedge clk); src_bus = '0;

        // R9: bypass follows the wire, rising mode ignored (bus bit 8)
        @(negedge clk); src_bus[8] = 1'b1;
        wr(10'h01C, mk_ctrl(1'b1, 2'd1, 6'd1, 3'd0));
        #1 check("R9 high", 32'(chan_out[3]), 32'd1);
        @(negedge clk); #1 check("R9 still high", 32'(chan_out[3]), 32'd1);
        src_bus[8] = 1'b0;
        #1 check("R9 follows low", 32'(chan_out[3]), 32'd0);

        // R10: software strobe on channel 4
        wr(10'h000, 32'h10);
        #1 check("R10 strobe high", 32'(chan_out[4]), 32'd1);
        @(negedge clk); #1 check("R10 strobe one clock", 32'(chan_out[4]), 32'd0);
        wr(10'h000, 32'h0);
        #1 check("R10 zero write", 32'(chan_out[4]), 32'd0);
        rd(10'h000, d); check("R10 read zero", d, 32'd0);

        // R11: software level on channel 5, combined with strobe
        wr(10'h004, 32'h20);
        #1 check("R11 level out", 32'(chan_out[5]), 32'd1);
        rd(10'h004, d); check("R11 level read", d, 32'h20);
        wr(10'h000, 32'h20);
        #1 check("R11 level xor strobe", 32'(chan_out[5]), 32'd0);
        @(negedge clk); #1 check("R11 level back", 32'(chan_out[5]), 32'd1);

        // R12: trace routing
        wr(10'h040, 32'h0000_000B);
        #1 check("R12 start ch5", {31'd0, trace_start}, 32'd1);
        check("R12 stop off", {31'd0, trace_stop}, 32'd0);
        wr(10'h040, 32'h0000_090B);
        #1 check("R12 stop ch4", {31'd0, trace_stop}, 32'd0);
        wr(10'h040, 32'h0000_0B0B);
        #1 check("R12 stop ch5", {31'd0, trace_stop}, 32'd1);
        wr(10'h040, 32'hFFFF_FFFF);
        rd(10'h040, d); check("R12 trace fields", d, 32'h0000_0F0F);
        check("R12 sel7 start", {31'd0, trace_start}, 32'd0);
        check("R12 sel7 stop", {31'd0, trace_stop}, 32'd0);

        // R13: unmapped offsets
        wr(10'h03C, 32'hFFFF_FFFF);
        wr(10'h008, 32'hFFFF_FFFF);
        rd(10'h03C, d); check("R13 read unmapped", d, 32'd0);
        rd(10'h004, d); check("R13 level kept", d, 32'h20);
        rd(10'h040, d); check("R13 trace kept", d, 32'h0000_0F0F);

        // R14: selecting an already-high source in rising mode (bus bit 25)
        @(negedge clk); src_bus[25] = 1'b1;
        wr(10'h014, mk_ctrl(1'b0, 2'd1, 6'd3, 3'd1));
        #1 check("R14 first pulse", 32'(chan_out[1]), 32'd1);
        @(negedge clk); #1 check("R14 pulse ends", 32'(chan_out[1]), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule